// File: doc/BRIEF.md
# Latched Error Status and Error/Warning Pin Driver

This block gathers the live fault and warning conditions of a position sensor into sticky status bits. Once a condition has been seen for one clock, its bit stays set until the host issues a status-clear command. The conditions are no-magnet, battery error, battery warning, supply-loss reset detected, overspeed, RAM checksum failure and startup fault. A power-down-reset bit that is still set tells the host that the last restart came from a supply loss. Clearing it acknowledges that the restart was intended.

The block drives two active-low pins. The error pin goes low when any sticky error bit that is enabled in a mask register is set. It is also held low while the device is in its startup phase, asleep, or under any reset condition, whatever the status bits hold. The warning pin goes low while any sticky warning bit is set. The host reads the status through a one-cycle read strobe, which captures a snapshot of the 16-bit status word.

Top module: `errstat_nerr_ctrl`

## Requirements
- R1: A condition input that is high during a clock edge sets its status bit from that edge onward. The bit stays set after the input falls, until a clear.
- R2: When `stat_clr_i` is high at an edge, every sticky bit is cleared at that edge. This takes precedence over any condition that is high in the same cycle.
- R3: If a condition is still high when the clear arrives, its bit reads 0 for one cycle and sets again at the next edge.
- R4: The status word layout is: bit 0 no-magnet, bit 1 battery error, bit 2 power-down reset detected, bit 3 RAM checksum fail, bit 4 startup fault, bit 8 battery warning, bit 9 overspeed. All other bits read 0.
- R5: `nerr_o` is 0 whenever a status bit i (i in 0..4) is set and mask bit i is 1. It is 1 when no state hold applies and no such pair exists.
- R6: `nerr_o` is 0 whenever `in_startup_i`, `in_sleep_i` or `in_reset_i` is high, with no dependence on the status bits.
- R7: After reset the error mask is all ones. A high `mask_wr_i` loads `mask_wdata_i` into the mask at the next edge.
- R8: `nwrn_o` is 0 exactly when status bit 8 or bit 9 is set.
- R9: A high `rd_stb_i` at an edge copies the status word into `rd_data_o`. Otherwise `rd_data_o` holds its value.
- R10: After synchronous reset, the status word and `rd_data_o` are 0, and both pins are 1 once the state inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nomag_i | input | 1 | Live no-magnet condition |
| bat_err_i | input | 1 | Live battery error condition |
| bat_wrn_i | input | 1 | Live battery warning condition |
| pdr_i | input | 1 | Supply-loss reset detected |
| ovspd_i | input | 1 | Live overspeed condition |
| crc_fail_i | input | 1 | RAM checksum failure |
| stup_fault_i | input | 1 | Startup fault |
| in_startup_i | input | 1 | Device is in its startup phase |
| in_sleep_i | input | 1 | Device is asleep |
| in_reset_i | input | 1 | A reset condition is active |
| stat_clr_i | input | 1 | Status-clear command |
| mask_wr_i | input | 1 | Error mask write strobe |
| mask_wdata_i | input | 5 | New error mask, bit i enables status bit i |
| rd_stb_i | input | 1 | Host read strobe |
| status_o | output | 16 | Live sticky status word |
| rd_data_o | output | 16 | Status snapshot taken on the read strobe |
| nerr_o | output | 1 | Active-low error pin |
| nwrn_o | output | 1 | Active-low warning pin |

## Verification
The case that matters most is a clear command and an active condition in the same cycle. The bench provokes it by holding the no-magnet input high across the clear. It expects the bit to read 0 for exactly one cycle and then 1 again. It also writes the mask and raises a pattern of conditions in the same cycle. It does this for every pair of the 32 mask values and the 32 error patterns, and predicts the error pin from the AND of the two. Finally, it raises each state hold while the status word is empty and expects the error pin to go low.

// File: rtl/errstat_pkg.sv
// Package: shared widths and bit positions of the sticky status word.
// Assumes a 16-bit status word, with errors in the low byte and warnings from bit 8.
package errstat_pkg;
    localparam int SW       = 16;  // status word width
    localparam int N_ERR    = 5;   // sticky error bits
    localparam int N_WRN    = 2;   // sticky warning bits
    localparam int ERR_BASE = 0;   // first error bit
    localparam int WRN_BASE = 8;   // first warning bit (battery warning)
    localparam int N_HOLD   = 3;   // state indicators forcing the error pin
endpackage

// File: rtl/errstat_latch_bank.sv
// Module: a bank of sticky bits. A high condition sets its bit; clear wins.
// Assumes the conditions are already synchronous to clk.
module errstat_latch_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] cond,
    output logic [W-1:0] lat
);
    // Purpose: set on condition, clear on command, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    lat <= '0;
        else if (clr)  lat <= '0;
        else           lat <= lat | cond;
    end
endmodule

// File: rtl/errstat_mask_reg.sv
// Module: enable mask choosing which sticky errors reach the error pin.
// Assumes all errors are enabled out of reset.
module errstat_mask_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    // Purpose: hold the mask, load it on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   mask <= '1;
        else if (wr)  mask <= wdata;
    end
endmodule

// File: rtl/errstat_pin_drv.sv
// Module: combinational drive of the active-low error and warning pins.
// Assumes the hold inputs are active high, with any one of them forcing the error pin low.
module errstat_pin_drv #(
    parameter int NE = 4,
    parameter int NW = 2,
    parameter int NH = 3
) (
    input  logic [NE-1:0] err_lat,
    input  logic [NE-1:0] mask,
    input  logic [NW-1:0] wrn_lat,
    input  logic [NH-1:0] hold,
    output logic          nerr,
    output logic          nwrn
);
    // Purpose: error pin low on an enabled error or any state hold.
    always_comb nerr = ~((|(err_lat & mask)) | (|hold));
    // Purpose: warning pin low on any sticky warning.
    always_comb nwrn = ~(|wrn_lat);
endmodule

// File: rtl/errstat_nerr_ctrl.sv
// Module: top of the latched status block. It gathers the conditions into sticky bits,
// drives the error and warning pins, and captures a snapshot of the status word on a read strobe.
// Assumes all inputs are synchronous to clk and reset is synchronous and active low.
module errstat_nerr_ctrl
    import errstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nomag_i,
    input  logic             bat_err_i,
    input  logic             bat_wrn_i,
    input  logic             pdr_i,
    input  logic             ovspd_i,
    input  logic             crc_fail_i,
    input  logic             stup_fault_i,
    input  logic             in_startup_i,
    input  logic             in_sleep_i,
    input  logic             in_reset_i,
    input  logic             stat_clr_i,
    input  logic             mask_wr_i,
    input  logic [N_ERR-1:0] mask_wdata_i,
    input  logic             rd_stb_i,
    output logic [SW-1:0]    status_o,
    output logic [SW-1:0]    rd_data_o,
    output logic             nerr_o,
    output logic             nwrn_o
);
    logic [N_ERR-1:0]  err_cond, err_lat, mask_q;
    logic [N_WRN-1:0]  wrn_cond, wrn_lat;
    logic [N_HOLD-1:0] hold;

    // Purpose: order the condition inputs into their status bit positions.
    always_comb begin
        err_cond = {stup_fault_i, crc_fail_i, pdr_i, bat_err_i, nomag_i};
        wrn_cond = {ovspd_i, bat_wrn_i};
        hold     = {in_reset_i, in_sleep_i, in_startup_i};
    end

    errstat_latch_bank #(.W(N_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .clr(stat_clr_i), .cond(err_cond), .lat(err_lat)
    );

    errstat_latch_bank #(.W(N_WRN)) u_wrn (
        .clk(clk), .rst_n(rst_n), .clr(stat_clr_i), .cond(wrn_cond), .lat(wrn_lat)
    );

    errstat_mask_reg #(.W(N_ERR)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr(mask_wr_i), .wdata(mask_wdata_i), .mask(mask_q)
    );

    errstat_pin_drv #(.NE(N_ERR), .NW(N_WRN), .NH(N_HOLD)) u_pins (
        .err_lat(err_lat), .mask(mask_q), .wrn_lat(wrn_lat), .hold(hold),
        .nerr(nerr_o), .nwrn(nwrn_o)
    );

    // Purpose: place each sticky bit in the status word, all unused bits zero.
    for (genvar b = 0; b < SW; b++) begin : g_word
        if (b >= ERR_BASE && b < ERR_BASE + N_ERR) begin : g_e
            assign status_o[b] = err_lat[b - ERR_BASE];
        end else if (b >= WRN_BASE && b < WRN_BASE + N_WRN) begin : g_w
            assign status_o[b] = wrn_lat[b - WRN_BASE];
        end else begin : g_z
            assign status_o[b] = 1'b0;
        end
    end

    // Purpose: capture the status word for the host on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_data_o <= '0;
        else if (rd_stb_i) rd_data_o <= status_o;
    end
endmodule

// File: rtl/errstat_nerr_ctrl_chk.sv
// Module: assertion checker bound to errstat_nerr_ctrl.
// Assumes it is attached through the bind at the end of this file.
module errstat_nerr_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        nomag_i,
    input logic        bat_wrn_i,
    input logic        in_startup_i,
    input logic        in_sleep_i,
    input logic        in_reset_i,
    input logic        stat_clr_i,
    input logic        mask_wr_i,
    input logic        rd_stb_i,
    input logic [4:0]  mask_q,
    input logic [15:0] status_o,
    input logic [15:0] rd_data_o,
    input logic        nerr_o,
    input logic        nwrn_o
);
    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (nomag_i && !stat_clr_i) |=> status_o[0]);
    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !stat_clr_i) |=> status_o[0]);
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr_i |=> (status_o == 16'h0000));
    p_reset_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_startup_i || in_sleep_i || in_reset_i) |-> !nerr_o);
    p_enabled_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o[4:0] & mask_q) != 5'd0) |-> !nerr_o);
    p_unused_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[15:10] == 6'd0) && (status_o[7:5] == 3'd0));
    p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_q));
    p_warn_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[9:8] != 2'd0) == !nwrn_o);
    p_bat_wrn_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_wrn_i && !stat_clr_i) |=> status_o[8]);
    p_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> (rd_data_o == $past(status_o)));
    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(rd_data_o));
endmodule

bind errstat_nerr_ctrl errstat_nerr_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nomag_i(nomag_i), .bat_wrn_i(bat_wrn_i),
    .in_startup_i(in_startup_i), .in_sleep_i(in_sleep_i), .in_reset_i(in_reset_i),
    .stat_clr_i(stat_clr_i), .mask_wr_i(mask_wr_i), .rd_stb_i(rd_stb_i),
    .mask_q(mask_q), .status_o(status_o), .rd_data_o(rd_data_o),
    .nerr_o(nerr_o), .nwrn_o(nwrn_o)
);

// File: tb/errstat_nerr_ctrl_test.sv
// Bench: sweeps the conditions, the mask/pattern pairs and the state holds.
// It computes the expected values from the requirement text.
module errstat_nerr_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic nomag_i, bat_err_i, bat_wrn_i, pdr_i, ovspd_i, crc_fail_i, stup_fault_i;
    logic in_startup_i, in_sleep_i, in_reset_i, stat_clr_i, mask_wr_i, rd_stb_i;
    logic [4:0]  mask_wdata_i;
    logic [15:0] status_o, rd_data_o;
    logic nerr_o, nwrn_o;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errstat_nerr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .nomag_i(nomag_i), .bat_err_i(bat_err_i),
        .bat_wrn_i(bat_wrn_i), .pdr_i(pdr_i), .ovspd_i(ovspd_i),
        .crc_fail_i(crc_fail_i), .stup_fault_i(stup_fault_i),
        .in_startup_i(in_startup_i), .in_sleep_i(in_sleep_i), .in_reset_i(in_reset_i),
        .stat_clr_i(stat_clr_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .rd_stb_i(rd_stb_i), .status_o(status_o), .rd_data_o(rd_data_o),
        .nerr_o(nerr_o), .nwrn_o(nwrn_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    // v order: 0 nomag, 1 bat_err, 2 pdr, 3 crc, 4 stup, 5 bat_wrn, 6 ovspd
    task automatic set_in(input logic [6:0] v);
        {ovspd_i, bat_wrn_i, stup_fault_i, crc_fail_i, pdr_i, bat_err_i, nomag_i} = v;
    endtask

    function automatic logic [15:0] word_of(input logic [6:0] v);
        return {6'd0, v[6:5], 3'd0, v[4:0]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        stat_clr_i = 1'b1;
        tick();
        stat_clr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        set_in(7'd0);
        {in_startup_i, in_sleep_i, in_reset_i, stat_clr_i, mask_wr_i, rd_stb_i} = '0;
        mask_wdata_i = '0;
        tick(); tick();
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 status", status_o, 16'h0);
        chk("R10 rd_data", rd_data_o, 16'h0);
        chk("R10 nerr", {15'd0, nerr_o}, 16'd1);
        chk("R10 nwrn", {15'd0, nwrn_o}, 16'd1);

        // R1, R4, R7 default mask, R8, R2: walk each condition
        for (int k = 0; k < 7; k++) begin
            logic [6:0] v;
            v = 7'd1 << k;
            set_in(v);
            tick();
            set_in(7'd0);
            chk("R1 R4 set", status_o, word_of(v));
            chk("R7 default mask nerr", {15'd0, nerr_o}, (k < 5) ? 16'd0 : 16'd1);
            chk("R8 nwrn", {15'd0, nwrn_o}, (k >= 5) ? 16'd0 : 16'd1);
            tick();
            chk("R1 sticky", status_o, word_of(v));
            do_clear();
            chk("R2 clear", status_o, 16'h0);
            chk("R8 nwrn after clear", {15'd0, nwrn_o}, 16'd1);
        end

        // R3 and R2 precedence: condition held across the clear
        set_in(7'h01);
        stat_clr_i = 1'b1;
        tick();
        stat_clr_i = 1'b0;
        chk("R3 cleared while active", status_o, 16'h0);
        tick();
        chk("R3 re-set", status_o, 16'h0001);
        set_in(7'd0);
        do_clear();
        chk("R2 final clear", status_o, 16'h0);

        // R5, R7: every mask against every error pattern
        for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 32; p++) begin
                set_in({2'b00, p[4:0]});
                mask_wr_i = 1'b1;
                mask_wdata_i = m[4:0];
                tick();
                set_in(7'd0);
                mask_wr_i = 1'b0;
                chk("R5 pattern", status_o, {11'd0, p[4:0]});
                chk("R5 R7 masked nerr", {15'd0, nerr_o},
                    ((p & m) != 0) ? 16'd0 : 16'd1);
                do_clear();
            end
        end
        mask_wr_i = 1'b1;
        mask_wdata_i = 5'h1f;
        tick();
        mask_wr_i = 1'b0;

        // R6: state holds with an empty status word
        for (int s = 0; s < 8; s++) begin
            {in_reset_i, in_sleep_i, in_startup_i} = s[2:0];
            tick();
            chk("R6 hold nerr", {15'd0, nerr_o}, (s != 0) ? 16'd0 : 16'd1);
            chk("R6 status untouched", status_o, 16'h0);
        end
        {in_reset_i, in_sleep_i, in_startup_i} = 3'd0;

        // R9: read snapshot, then hold
        set_in(7'h20);
        tick();
        set_in(7'd0);
        rd_stb_i = 1'b1;
        tick();
        rd_stb_i = 1'b0;
        chk("R9 capture", rd_data_o, 16'h0100);
        do_clear();
        tick();
        chk("R9 hold", rd_data_o, 16'h0100);
        rd_stb_i = 1'b1;
        tick();
        rd_stb_i = 1'b0;
        chk("R9 recapture", rd_data_o, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule